// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a cache and watches the demand misses that reach it. When a miss is not already covered, it claims one of several small stream buffers. That buffer requests the missed block and the blocks that follow it in address order. It keeps the returned data in its own FIFO, apart from the cache array. Each buffer follows its own stream, so several sequential walks can run at the same time without disturbing one another.

Every demand request is compared with the oldest entry (the head) of each active buffer. A match on a head whose data has arrived answers the request as a hit. It retires that entry, and the freed slot is used to fetch the next block of the stream, so the buffer keeps running ahead of the consumer. A match on a head whose data is still outstanding holds the request until the data returns. When every buffer is in use, a new stream takes the least recently used buffer. Any data still owed to that buffer's old stream is thrown away when it arrives.

Addresses on every port are block addresses, so the next block is address + 1. Prefetch requests carry an identifier that memory echoes back with the data. This lets responses return in any order.

Top module: `sbp_prefetcher`

## Requirements
- R1: After reset, req_ready is 1, pf_valid is 0 and rsp_valid is 0.
- R2: An accepted request with req_miss=1 that matches no buffer head allocates a buffer. Each buffer has an epoch bit that is 0 after reset and flips on every allocation. The buffer then offers DEPTH prefetches for A, A+1, ..., A+DEPTH-1 in that order, in slots 0 to DEPTH-1.
- R3: Every accepted request produces rsp_valid exactly one cycle later. On a hit, rsp_hit=1 and rsp_data holds the filled data. On a miss, rsp_hit=0 and rsp_data=0.
- R4: Only head entries are compared. A request that matches a non-head entry of a buffer is answered as a miss.
- R5: A hit retires the head entry. The same buffer then offers a prefetch for the block after the last address it assigned.
- R6: While a request matches a head whose data has not yet been filled, req_ready stays 0 and no response is produced. The request is answered as a hit once the fill lands.
- R7: pf_id and fill_id are laid out as {epoch, buffer index, slot}, with the slot in the least significant bits. A fill is written to the entry it names, whatever order fills return in.
- R8: Allocation picks the lowest-numbered buffer that has never been allocated, as long as one exists.
- R9: When every buffer is active, allocation takes the least recently used buffer (use means allocation or hit) and discards its old entries. A fill whose epoch differs from the buffer's current epoch is ignored.
- R10: At most one prefetch is offered per cycle. Buffers are served round-robin, starting after the buffer granted last. pf_valid stays high while pf_ready is low.
- R11: A request with req_miss=0 that matches no head allocates nothing and starts no prefetch.
- R12: A request with req_miss=1 that hits a ready head is served as a hit. It does not allocate a new buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| req_valid | input | 1 | Demand request present |
| req_miss | input | 1 | 1: the request is a cache miss and may allocate; 0: lookup only |
| req_addr | input | ADDR_W | Requested block address |
| req_ready | output | 1 | Request accepted this cycle; 0 while waiting on a pending head |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_hit | output | 1 | Response came from a stream buffer |
| rsp_data | output | DATA_W | Block data on a hit, zero on a miss |
| pf_valid | output | 1 | Prefetch request offered to memory |
| pf_ready | input | 1 | Memory accepts the prefetch request |
| pf_addr | output | ADDR_W | Block address to prefetch |
| pf_id | output | 1+log2(NUM_BUF)+log2(DEPTH) | {epoch, buffer, slot} tag that memory must return with the data |
| fill_valid | input | 1 | Prefetch data returning |
| fill_id | input | 1+log2(NUM_BUF)+log2(DEPTH) | Tag copied from the matching pf_id |
| fill_data | input | DATA_W | Returned block data |

## Verification
The hardest states to reach are a buffer replaced while one of its fills is still owed, and a request blocked on a head entry that is still pending. The stimulus sets up the first case by making all four buffers busy with pf_ready held low, so that the least recently used buffer is the one that gets replaced. It then returns a fill carrying that buffer's old epoch and probes the head to show the fill was ignored. The pending-head stall is reached by deliberately withholding the slot-0 fill while a request for that block is held on the port.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_NEED  = 2'd1,
    SLOT_WAIT  = 2'd2,
    SLOT_READY = 2'd3
  } slot_state_e;
endpackage

// File: rtl/sbp_rr_arb.sv
module sbp_rr_arb #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  input  logic             adv_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    logic found;
    int   c;
    found = 1'b0;
    gnt_o = '0;
    idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(ptr_q) + k) % N;
      if (!found && req_i[c]) begin
        found    = 1'b1;
        gnt_o[c] = 1'b1;
        idx_o    = IDX_W'(c);
      end
    end
  end

  assign ptr_en = adv_i && (|req_i);
  assign ptr_d  = idx_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= IDX_W'(N - 1);
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o));
  // R10
  gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/sbp_lru.sv
module sbp_lru #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [N-1:0]     busy_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] age_d [N];
  logic [N-1:0]     oldest_v;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (IDX_W'(i) == touch_idx_i)          age_d[i] = '0;
      else if (age_q[i] < age_q[touch_idx_i]) age_d[i] = age_q[i] + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  always_comb begin
    logic free_found;
    free_found = 1'b0;
    victim_o   = '0;
    for (int i = 0; i < N; i++) begin
      oldest_v[i] = (age_q[i] == IDX_W'(N - 1));
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (oldest_v[i]) victim_o = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (!free_found && !busy_i[i]) begin
        free_found = 1'b1;
        victim_o   = IDX_W'(i);
      end
    end
  end

  // R9
  age_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(oldest_v) == 1);
endmodule

// File: rtl/sbp_stream.sv
module sbp_stream
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              head_match_o,
  output logic              head_ready_o,
  output logic [DATA_W-1:0] head_data_o,
  input  logic              pop_i,
  output logic              iss_req_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  output logic [SLOT_W-1:0] iss_slot_o,
  output logic              epoch_o,
  input  logic              iss_gnt_i,
  input  logic              fill_i,
  input  logic [SLOT_W-1:0] fill_slot_i,
  input  logic              fill_epoch_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  logic              active_q, active_d;
  logic              epoch_q, epoch_d;
  logic [SLOT_W-1:0] head_q, head_d;
  logic [ADDR_W-1:0] next_q, next_d;
  slot_state_e       st_q  [DEPTH];
  slot_state_e       st_d  [DEPTH];
  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [ADDR_W-1:0] tag_d [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic              fill_hit, tag_en, dat_en;
  logic              sel_found;
  logic [SLOT_W-1:0] sel_slot;

  assign fill_hit = fill_i && active_q && (fill_epoch_i == epoch_q)
                    && (st_q[fill_slot_i] == SLOT_WAIT);
  assign dat_en   = fill_hit && !alloc_i;
  assign tag_en   = alloc_i || pop_i;

  // oldest entry still needing a prefetch, scanning from the head
  always_comb begin
    logic [SLOT_W-1:0] cand;
    cand      = '0;
    sel_found = 1'b0;
    sel_slot  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      cand = head_q + SLOT_W'(i);
      if (!sel_found && st_q[cand] == SLOT_NEED) begin
        sel_found = 1'b1;
        sel_slot  = cand;
      end
    end
  end

  assign iss_req_o  = active_q && sel_found;
  assign iss_addr_o = tag_q[sel_slot];
  assign iss_slot_o = sel_slot;
  assign epoch_o    = epoch_q;

  assign head_match_o = active_q && (st_q[head_q] != SLOT_EMPTY)
                        && (tag_q[head_q] == look_addr_i);
  assign head_ready_o = head_match_o && (st_q[head_q] == SLOT_READY);
  assign head_data_o  = dat_q[head_q];

  always_comb begin
    active_d = active_q;
    epoch_d  = epoch_q;
    head_d   = head_q;
    next_d   = next_q;
    st_d     = st_q;
    tag_d    = tag_q;
    if (alloc_i) begin
      active_d = 1'b1;
      epoch_d  = ~epoch_q;
      head_d   = '0;
      next_d   = alloc_addr_i + ADDR_W'(DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
        tag_d[i] = alloc_addr_i + ADDR_W'(i);
        st_d[i]  = SLOT_NEED;
      end
    end else begin
      if (iss_gnt_i && iss_req_o) st_d[sel_slot] = SLOT_WAIT;
      if (fill_hit)               st_d[fill_slot_i] = SLOT_READY;
      if (pop_i) begin
        st_d[head_q]  = SLOT_NEED;
        tag_d[head_q] = next_q;
        next_d        = next_q + ADDR_W'(1);
        head_d        = head_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      epoch_q  <= 1'b0;
      head_q   <= '0;
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_EMPTY;
    end else begin
      active_q <= active_d;
      epoch_q  <= epoch_d;
      head_q   <= head_d;
      st_q     <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_en) begin
      next_q <= next_d;
      tag_q  <= tag_d;
    end
    if (dat_en) dat_q[fill_slot_i] <= fill_data_i;
  end

  // R2
  alloc_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> iss_req_o && !head_ready_o);
  // R5
  pop_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !alloc_i) |=> iss_req_o);
endmodule

// File: rtl/sbp_prefetcher.sv
module sbp_prefetcher #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  localparam int BUF_W  = $clog2(NUM_BUF),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int ID_W   = 1 + BUF_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_miss,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [ID_W-1:0]   pf_id,
  input  logic              fill_valid,
  input  logic [ID_W-1:0]   fill_id,
  input  logic [DATA_W-1:0] fill_data
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  logic [NUM_BUF-1:0] match_v, ready_v, iss_req_v, epoch_v, gnt_v;
  logic [NUM_BUF-1:0] alloc_v, pop_v, fill_v, iss_gnt_v, active_v;
  logic [DATA_W-1:0]  hdata [NUM_BUF];
  logic [ADDR_W-1:0]  iaddr [NUM_BUF];
  logic [SLOT_W-1:0]  islot [NUM_BUF];
  logic [BUF_W-1:0]   hit_idx, victim, gnt_idx, touch_idx;
  logic               hit_any, wait_any, accept, do_pop, do_alloc, pf_fire;
  logic               fill_epoch;
  logic [BUF_W-1:0]   fill_buf;
  logic [SLOT_W-1:0]  fill_slot;

  assign hit_any  = |ready_v;
  assign wait_any = |(match_v & ~ready_v);
  assign req_ready = hit_any || !wait_any;
  assign accept    = req_valid && req_ready;
  assign do_pop    = accept && hit_any;
  assign do_alloc  = accept && !hit_any && req_miss;

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (ready_v[i]) hit_idx = BUF_W'(i);
    end
  end

  assign fill_epoch = fill_id[ID_W-1];
  assign fill_buf   = fill_id[SLOT_W +: BUF_W];
  assign fill_slot  = fill_id[SLOT_W-1:0];

  assign pf_fire   = pf_valid && pf_ready;
  assign iss_gnt_v = gnt_v & {NUM_BUF{pf_fire}};
  assign touch_idx = do_pop ? hit_idx : victim;

  genvar g;
  generate
    for (g = 0; g < NUM_BUF; g++) begin : g_buf
      logic active_seen_q;
      assign pop_v[g]   = do_pop && (hit_idx == BUF_W'(g));
      assign alloc_v[g] = do_alloc && (victim == BUF_W'(g));
      assign fill_v[g]  = fill_valid && (fill_buf == BUF_W'(g));
      assign active_v[g] = active_seen_q;

      always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int)    active_seen_q <= 1'b0;
        else if (alloc_v[g]) active_seen_q <= 1'b1;
      end

      sbp_stream #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
      ) u_stream (
        .clk          (clk),
        .rst_n        (rst_n_int),
        .alloc_i      (alloc_v[g]),
        .alloc_addr_i (req_addr),
        .look_addr_i  (req_addr),
        .head_match_o (match_v[g]),
        .head_ready_o (ready_v[g]),
        .head_data_o  (hdata[g]),
        .pop_i        (pop_v[g]),
        .iss_req_o    (iss_req_v[g]),
        .iss_addr_o   (iaddr[g]),
        .iss_slot_o   (islot[g]),
        .epoch_o      (epoch_v[g]),
        .iss_gnt_i    (iss_gnt_v[g]),
        .fill_i       (fill_v[g]),
        .fill_slot_i  (fill_slot),
        .fill_epoch_i (fill_epoch),
        .fill_data_i  (fill_data)
      );
    end
  endgenerate

  sbp_rr_arb #(.N(NUM_BUF)) u_arb (
    .clk   (clk),
    .rst_n (rst_n_int),
    .req_i (iss_req_v),
    .adv_i (pf_fire),
    .gnt_o (gnt_v),
    .idx_o (gnt_idx)
  );

  sbp_lru #(.N(NUM_BUF)) u_lru (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .touch_i     (do_pop || do_alloc),
    .touch_idx_i (touch_idx),
    .busy_i      (active_v),
    .victim_o    (victim)
  );

  assign pf_valid = |iss_req_v;
  assign pf_addr  = iaddr[gnt_idx];
  assign pf_id    = {epoch_v[gnt_idx], gnt_idx, islot[gnt_idx]};

  logic              rsp_valid_q, rsp_hit_q, rsp_hit_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  assign rsp_hit_d  = hit_any;
  assign rsp_data_d = hit_any ? hdata[hit_idx] : '0;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) rsp_hit_q <= rsp_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) rsp_data_q <= rsp_data_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;

  // R10
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pf_valid && !pf_ready) |=> pf_valid);
  // R6
  stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && !req_ready) |=> !rsp_valid);
endmodule

// File: tb/sim_sbp_prefetcher.sv
module sim_sbp_prefetcher;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int IDW = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_valid, req_miss, req_ready;
  logic [AW-1:0]  req_addr;
  logic           rsp_valid, rsp_hit;
  logic [DW-1:0]  rsp_data;
  logic           pf_valid, pf_ready;
  logic [AW-1:0]  pf_addr;
  logic [IDW-1:0] pf_id;
  logic           fill_valid;
  logic [IDW-1:0] fill_id;
  logic [DW-1:0]  fill_data;

  always #2.5ns clk = ~clk;

  sbp_prefetcher #(.NUM_BUF(4), .DEPTH(4), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_miss(req_miss),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_id(pf_id),
    .fill_valid(fill_valid), .fill_id(fill_id), .fill_data(fill_data)
  );

  int n_chk = 0;
  int n_err = 0;

  // fields: addr[34:19] miss[18] exp_hit[17] exp_pf[16] exp_pf_addr[15:0]
  localparam logic [34:0] VECS [4] = '{
    {16'h0100, 1'b0, 1'b1, 1'b1, 16'h0104},
    {16'h0102, 1'b0, 1'b0, 1'b0, 16'h0000},
    {16'h0101, 1'b0, 1'b1, 1'b1, 16'h0105},
    {16'h0102, 1'b1, 1'b1, 1'b1, 16'h0106}
  };

  function automatic logic [DW-1:0] dv(input logic [AW-1:0] a);
    return a ^ 16'hA5A5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic m);
    req_addr = a; req_miss = m; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    #1ns;
  endtask

  task automatic take(input string tag, output logic [AW-1:0] a, output logic [IDW-1:0] id);
    chk(tag, pf_valid, 1'b1);
    a = pf_addr; id = pf_id;
    pf_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    pf_ready = 1'b0;
    #1ns;
  endtask

  task automatic give(input logic [IDW-1:0] id, input logic [DW-1:0] d);
    fill_id = id; fill_data = d; fill_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    #1ns;
  endtask

  initial begin
    #1ms;
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [AW-1:0]  a;
    logic [IDW-1:0] id;
    rst_n = 1'b0; req_valid = 1'b0; req_miss = 1'b0; req_addr = '0;
    pf_ready = 1'b0; fill_valid = 1'b0; fill_id = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1ns;
    chk("R1 req_ready", req_ready, 1'b1);
    chk("R1 pf_valid", pf_valid, 1'b0);
    chk("R1 rsp_valid", rsp_valid, 1'b0);

    // first miss: allocate buffer 0
    lookup(16'h0100, 1'b1);
    chk("R3 miss rsp_valid", rsp_valid, 1'b1);
    chk("R3 miss rsp_hit", rsp_hit, 1'b0);
    chk("R3 miss rsp_data", rsp_data, 16'h0);
    for (int i = 0; i < 4; i++) begin
      take("R2 prefetch offered", a, id);
      chk("R2 prefetch addr", a, 16'h0100 + i);
      chk("R2 R8 prefetch id", id, {1'b1, 2'd0, 2'(i)});
    end
    chk("R2 only DEPTH prefetches", pf_valid, 1'b0);
    // R7: fills return in reverse order
    for (int i = 3; i >= 0; i--) give({1'b1, 2'd0, 2'(i)}, dv(16'h0100 + 16'(i)));

    // table walk: hits, a non-head lookup, a miss that hits a head
    for (int v = 0; v < 4; v++) begin
      lookup(VECS[v][34:19], VECS[v][18]);
      chk("R3 R4 rsp_valid", rsp_valid, 1'b1);
      chk("R3 R4 rsp_hit", rsp_hit, VECS[v][17]);
      chk("R3 R7 rsp_data", rsp_data, VECS[v][17] ? dv(VECS[v][34:19]) : 16'h0);
      chk("R5 R11 pf_valid after lookup", pf_valid, VECS[v][16]);
      if (VECS[v][16]) begin
        take("R5 refill prefetch", a, id);
        chk("R5 refill addr", a, VECS[v][15:0]);
        give(id, dv(a));
      end
    end

    // second stream: lowest free buffer, then a stall on a pending head
    lookup(16'h0200, 1'b1);
    for (int i = 0; i < 4; i++) begin
      take("R8 prefetch offered", a, id);
      chk("R8 second buffer id", id, {1'b1, 2'd1, 2'(i)});
    end
    for (int i = 1; i < 4; i++) give({1'b1, 2'd1, 2'(i)}, dv(16'h0200 + 16'(i)));
    req_addr = 16'h0200; req_miss = 1'b0; req_valid = 1'b1;
    #1ns;
    chk("R6 stall while pending", req_ready, 1'b0);
    @(negedge clk); #1ns;
    chk("R6 still stalled", req_ready, 1'b0);
    chk("R6 no response while stalled", rsp_valid, 1'b0);
    fill_id = {1'b1, 2'd1, 2'd0}; fill_data = dv(16'h0200); fill_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    #1ns;
    chk("R6 released after fill", req_ready, 1'b1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    #1ns;
    chk("R6 hit after wait", rsp_hit, 1'b1);
    chk("R6 data after wait", rsp_data, dv(16'h0200));
    take("R5 refill buffer1", a, id);
    chk("R5 refill buffer1 addr", a, 16'h0204);
    give(id, dv(a));

    // round-robin between buffers 2 and 3, pf_ready held low meanwhile
    lookup(16'h0300, 1'b1);
    chk("R10 pf pending", pf_valid, 1'b1);
    lookup(16'h0400, 1'b1);
    chk("R10 pf held while not ready", pf_valid, 1'b1);
    for (int i = 0; i < 8; i++) begin
      take("R10 prefetch offered", a, id);
      chk("R10 rr buffer", id[3:2], 2'd2 + 2'(i % 2));
      chk("R10 rr addr", a, ((i % 2) != 0 ? 16'h0400 : 16'h0300) + 16'(i / 2));
    end
    chk("R10 all issued", pf_valid, 1'b0);

    // all busy: LRU (buffer 0) replaced
    lookup(16'h0500, 1'b1);
    for (int i = 0; i < 4; i++) begin
      take("R9 prefetch offered", a, id);
      chk("R9 replaced buffer id", id, {1'b0, 2'd0, 2'(i)});
      chk("R9 replaced buffer addr", a, 16'h0500 + i);
    end
    lookup(16'h0103, 1'b0);
    chk("R9 flushed entry misses", rsp_hit, 1'b0);
    give({1'b1, 2'd0, 2'd0}, 16'hDEAD);
    req_addr = 16'h0500; req_miss = 1'b0; req_valid = 1'b1;
    #1ns;
    chk("R9 stale fill ignored", req_ready, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    give({1'b0, 2'd0, 2'd0}, dv(16'h0500));
    give({1'b0, 2'd0, 2'd1}, dv(16'h0501));
    lookup(16'h0500, 1'b0);
    chk("R9 new stream hit", rsp_hit, 1'b1);
    chk("R9 new stream data", rsp_data, dv(16'h0500));
    take("R5 refill after replace", a, id);
    chk("R5 refill after replace addr", a, 16'h0504);

    // miss flagged request that hits a ready head
    lookup(16'h0501, 1'b1);
    chk("R12 miss served as hit", rsp_hit, 1'b1);
    chk("R12 data", rsp_data, dv(16'h0501));
    take("R12 refill only", a, id);
    chk("R12 refill addr", a, 16'h0505);
    chk("R12 refill buffer", id[3:2], 2'd0);
    chk("R12 no new allocation", pf_valid, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule